// File: doc/BRIEF.md
# Linked-List Multi-Queue Pointer Controller

This block keeps many FIFO queues of fixed-size segments as singly linked lists. It stores every piece of pointer state in one single-port synchronous memory. That state is the next-pointer of each segment, the head and tail words of each queue, and the emptiness of each queue. A client hands in an enqueue (queue number plus a free segment address) or a dequeue (queue number). The block answers with a one-cycle completion pulse. For a dequeue, the pulse carries the removed segment address or an empty indication.

The memory is pipelined. Read data for an address presented at one edge is sampled two edges later, so an access whose address depends on read data comes three cycles after the read. The sequencer issues at most one access per cycle. The first read of each operation tells it whether the normal or the exceptional path applies, and it then issues only the accesses that path needs. Operations never overlap. Emptiness is held either as a flag bit beside the pointer or as a reserved pointer value. A parameter picks the scheme, and both schemes behave the same at the ports.

Top module: `llq_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low while the block writes the empty encoding into every head word and every tail word. That is 2*NQ writes, one per cycle. Then `req_ready` rises, and every queue reads as empty.
- R2: Memory layout: the next-pointer of segment s is at address s, the head word of queue q at NSEG+q, and the tail word at NSEG+NQ+q. In the flag scheme a word is {empty bit, pointer}. In the reserved-value scheme a word is the pointer, and the value NSEG means empty. With the defaults the empty word reads 64 in both schemes, and a non-empty word equals the segment address.
- R3: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until completion. A request offered while busy is dropped, and the block makes no memory access while `req_ready` is high.
- R4: An enqueue to an empty queue makes three accesses: read the tail word, write the head word, then write the tail word. Both writes hold the new segment as non-empty. Completion comes 5 edges after acceptance.
- R5: An enqueue to a non-empty queue makes three accesses: read the tail word, write the new segment into the next-pointer of the old tail, then write the tail word. Completion comes 5 edges after acceptance.
- R6: A dequeue of an empty queue makes one access, the head read. It completes 3 edges after acceptance with `done_empty` high.
- R7: A dequeue of the only element makes four accesses: read the head word, read the tail word, write empty into the head word, then write empty into the tail word. It returns the head segment 8 edges after acceptance.
- R8: A dequeue from a queue holding two or more elements makes four accesses: read the head word, read the tail word, read the next-pointer, then write the head word. It returns the head segment 10 edges after acceptance, and each queue delivers its segments in enqueue order.
- R9: After a memory read, the block issues no access of any kind during the next two cycles.
- R10: `done_valid` is a one-cycle pulse, and `req_ready` is high in the same cycle. `done_empty` is high only together with `done_valid`.
- R11: With the reserved-value scheme the block gives the same results, access counts and timing as with the flag scheme.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_op | input | 1 | 0 = enqueue, 1 = dequeue |
| req_qid | input | QW | Queue number |
| req_seg | input | SW | Segment address to enqueue |
| done_valid | output | 1 | Operation finished (one cycle) |
| done_empty | output | 1 | Dequeue found the queue empty |
| done_seg | output | SW | Dequeued segment (enqueued one for enqueue) |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | WW | Write word |
| mem_rdata | input | WW | Read word, two edges after the address |

## Verification
The hardest case to reach is the hand-over between exceptional and normal paths on one queue. The last dequeue must mark both the head and tail words empty, so that the next enqueue takes the empty-queue path and rebuilds the head. The bench reaches it by filling and draining queues to empty and back again, both in an alternating pattern across five queues and in one long fill and drain. A request held high during a busy enqueue, aimed at an otherwise idle queue, shows that requests offered while busy are dropped. Flag and reserved-value instances run side by side on identical stimulus, each with its own pipelined memory model.

// File: rtl/llq_pkg.sv
package llq_pkg;

   typedef enum logic [3:0] {
      ST_INIT_H, ST_INIT_T, ST_IDLE,
      ST_ENQ_RT, ST_ENQ_WN, ST_ENQ_WH, ST_ENQ_WT,
      ST_DQ_RH, ST_DQ_RT, ST_DQ_RN, ST_DQ_WH, ST_DQ_EH, ST_DQ_ET,
      ST_WAIT
   } llq_state_e;

   typedef enum logic [1:0] {TAG_ENQ_T, TAG_DQ_H, TAG_DQ_T, TAG_DQ_N} llq_tag_e;

   typedef enum logic [1:0] {AREA_NXT, AREA_HEAD, AREA_TAIL} llq_area_e;

   localparam logic OP_ENQ = 1'b0;
   localparam logic OP_DEQ = 1'b1;

endpackage

// File: rtl/llq_addr_map.sv
module llq_addr_map
   import llq_pkg::*;
#(
   parameter int NSEG = 64,
   parameter int NQ   = 8,
   parameter int SW   = 6,
   parameter int QW   = 3,
   parameter int AW   = 7
) (
   input  llq_area_e        area,
   input  logic [QW-1:0]    qid,
   input  logic [SW-1:0]    seg,
   output logic [AW-1:0]    addr
);

   always_comb begin
      case (area)
         AREA_HEAD: addr = AW'(NSEG) + AW'(qid);
         AREA_TAIL: addr = AW'(NSEG + NQ) + AW'(qid);
         default:   addr = AW'(seg);
      endcase
   end

endmodule

// File: rtl/llq_word_codec.sv
module llq_word_codec #(
   parameter int NSEG         = 64,
   parameter int SW           = 6,
   parameter int WW           = 7,
   parameter bit USE_NULL_PTR = 1'b0
) (
   input  logic          enc_empty,
   input  logic [SW-1:0] enc_ptr,
   output logic [WW-1:0] enc_word,
   input  logic [WW-1:0] dec_word,
   output logic          dec_empty,
   output logic [SW-1:0] dec_ptr
);

   generate
      if (USE_NULL_PTR) begin : g_null
         if (WW < $clog2(NSEG + 1)) begin : g_bad_ww
            $error("llq_word_codec: word too narrow for reserved value");
         end
         assign enc_word  = enc_empty ? WW'(NSEG) : WW'(enc_ptr);
         assign dec_empty = (dec_word == WW'(NSEG));
         assign dec_ptr   = dec_word[SW-1:0];
      end else begin : g_flag
         if (WW != SW + 1) begin : g_bad_ww
            $error("llq_word_codec: flag scheme needs pointer plus one bit");
         end
         assign enc_word  = {enc_empty, enc_ptr};
         assign dec_empty = dec_word[WW-1];
         assign dec_ptr   = dec_word[SW-1:0];
      end
   endgenerate

endmodule

// File: rtl/llq_ctrl.sv
module llq_ctrl
   import llq_pkg::*;
#(
   parameter  int NSEG         = 64,
   parameter  int NQ           = 8,
   parameter  int RD_LAT       = 2,
   parameter  bit USE_NULL_PTR = 1'b0,
   localparam int SW = $clog2(NSEG),
   localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
   localparam int AW = $clog2(NSEG + 2 * NQ),
   localparam int WW = USE_NULL_PTR ? $clog2(NSEG + 1) : SW + 1,
   localparam int CW = $clog2(RD_LAT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_op,
   input  logic [QW-1:0] req_qid,
   input  logic [SW-1:0] req_seg,
   output logic          done_valid,
   output logic          done_empty,
   output logic [SW-1:0] done_seg,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [WW-1:0] mem_wdata,
   input  logic [WW-1:0] mem_rdata
);

   if (NSEG < 2) begin : g_chk_nseg
      $error("llq_ctrl: NSEG must be at least 2");
   end
   if (NQ < 1) begin : g_chk_nq
      $error("llq_ctrl: NQ must be at least 1");
   end
   if (RD_LAT < 1) begin : g_chk_lat
      $error("llq_ctrl: RD_LAT must be at least 1");
   end

   llq_state_e    state;
   llq_tag_e      tag;
   logic [CW-1:0] wcnt;
   logic [QW-1:0] cur_q, init_q;
   logic [SW-1:0] cur_seg, ptr_a, ptr_b;

   llq_area_e     area;
   logic [QW-1:0] a_q;
   logic [SW-1:0] a_seg;
   logic          enc_empty;
   logic [SW-1:0] enc_ptr;
   logic          dec_empty;
   logic [SW-1:0] dec_ptr;

   llq_addr_map #(.NSEG(NSEG), .NQ(NQ), .SW(SW), .QW(QW), .AW(AW)) amap_i (
      .area(area), .qid(a_q), .seg(a_seg), .addr(mem_addr)
   );

   llq_word_codec #(.NSEG(NSEG), .SW(SW), .WW(WW), .USE_NULL_PTR(USE_NULL_PTR)) codec_i (
      .enc_empty(enc_empty), .enc_ptr(enc_ptr), .enc_word(mem_wdata),
      .dec_word(mem_rdata), .dec_empty(dec_empty), .dec_ptr(dec_ptr)
   );

   assign req_ready = (state == ST_IDLE);

   always_comb begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      area      = AREA_NXT;
      a_q       = cur_q;
      a_seg     = ptr_a;
      enc_empty = 1'b0;
      enc_ptr   = cur_seg;
      case (state)
         ST_INIT_H: begin area = AREA_HEAD; a_q = init_q; enc_empty = 1'b1; enc_ptr = '0; end
         ST_INIT_T: begin area = AREA_TAIL; a_q = init_q; enc_empty = 1'b1; enc_ptr = '0; end
         ST_ENQ_RT: begin area = AREA_TAIL; mem_we = 1'b0; end
         ST_ENQ_WN: area = AREA_NXT;
         ST_ENQ_WH: area = AREA_HEAD;
         ST_ENQ_WT: area = AREA_TAIL;
         ST_DQ_RH:  begin area = AREA_HEAD; mem_we = 1'b0; end
         ST_DQ_RT:  begin area = AREA_TAIL; mem_we = 1'b0; end
         ST_DQ_RN:  begin area = AREA_NXT;  mem_we = 1'b0; end
         ST_DQ_WH:  begin area = AREA_HEAD; enc_ptr = ptr_b; end
         ST_DQ_EH:  begin area = AREA_HEAD; enc_empty = 1'b1; enc_ptr = '0; end
         ST_DQ_ET:  begin area = AREA_TAIL; enc_empty = 1'b1; enc_ptr = '0; end
         default:   begin mem_en = 1'b0; mem_we = 1'b0; end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_INIT_H;
         tag        <= TAG_ENQ_T;
         wcnt       <= '0;
         cur_q      <= '0;
         init_q     <= '0;
         cur_seg    <= '0;
         ptr_a      <= '0;
         ptr_b      <= '0;
         done_valid <= 1'b0;
         done_empty <= 1'b0;
         done_seg   <= '0;
      end else begin
         done_valid <= 1'b0;
         done_empty <= 1'b0;
         case (state)
            ST_INIT_H: state <= ST_INIT_T;
            ST_INIT_T: begin
               if (init_q == QW'(NQ - 1)) begin
                  state <= ST_IDLE;
               end else begin
                  init_q <= init_q + 1'b1;
                  state  <= ST_INIT_H;
               end
            end
            ST_IDLE: begin
               if (req_valid) begin
                  cur_q   <= req_qid;
                  cur_seg <= req_seg;
                  state   <= (req_op == OP_ENQ) ? ST_ENQ_RT : ST_DQ_RH;
               end
            end
            ST_ENQ_RT: begin tag <= TAG_ENQ_T; wcnt <= CW'(RD_LAT - 1); state <= ST_WAIT; end
            ST_DQ_RH:  begin tag <= TAG_DQ_H;  wcnt <= CW'(RD_LAT - 1); state <= ST_WAIT; end
            ST_DQ_RT:  begin tag <= TAG_DQ_T;  wcnt <= CW'(RD_LAT - 1); state <= ST_WAIT; end
            ST_DQ_RN:  begin tag <= TAG_DQ_N;  wcnt <= CW'(RD_LAT - 1); state <= ST_WAIT; end
            ST_WAIT: begin
               if (wcnt != '0) begin
                  wcnt <= wcnt - 1'b1;
               end else begin
                  case (tag)
                     TAG_ENQ_T: begin
                        ptr_a <= dec_ptr;
                        state <= dec_empty ? ST_ENQ_WH : ST_ENQ_WN;
                     end
                     TAG_DQ_H: begin
                        if (dec_empty) begin
                           done_valid <= 1'b1;
                           done_empty <= 1'b1;
                           done_seg   <= '0;
                           state      <= ST_IDLE;
                        end else begin
                           ptr_a <= dec_ptr;
                           state <= ST_DQ_RT;
                        end
                     end
                     TAG_DQ_T: state <= (dec_ptr == ptr_a) ? ST_DQ_EH : ST_DQ_RN;
                     default: begin
                        ptr_b <= dec_ptr;
                        state <= ST_DQ_WH;
                     end
                  endcase
               end
            end
            ST_ENQ_WN, ST_ENQ_WH: state <= ST_ENQ_WT;
            ST_ENQ_WT: begin
               done_valid <= 1'b1;
               done_seg   <= cur_seg;
               state      <= ST_IDLE;
            end
            ST_DQ_EH: state <= ST_DQ_ET;
            ST_DQ_WH, ST_DQ_ET: begin
               done_valid <= 1'b1;
               done_seg   <= ptr_a;
               state      <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/llq_ctrl_chk.sv
module llq_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic mem_en,
   input logic mem_we,
   input logic done_valid,
   input logic done_empty
);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);                                  // R10
   AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> req_ready);                                    // R10
   AST_EMPTY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      done_empty |-> done_valid);                                   // R10
   AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_en);                                       // R3
   AST_READ_GAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we) |=> !mem_en);                             // R9
   AST_READ_GAP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mem_en && !mem_we, 2) |-> !mem_en);                     // R9

endmodule

bind llq_ctrl llq_ctrl_chk chk_i (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_en(mem_en),
   .mem_we(mem_we), .done_valid(done_valid), .done_empty(done_empty)
);

// File: tb/llq_ctrl_tb_top.sv
`timescale 1ns/1ps

module llq_tb_sram #(
   parameter int AW = 7,
   parameter int WW = 7
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [WW-1:0] wdata,
   output logic [WW-1:0] rdata
);
   logic [WW-1:0] mem [2**AW];
   logic [WW-1:0] stage1;

   initial begin
      for (int i = 0; i < 2**AW; i++) mem[i] = '0;
      stage1 = '0;
      rdata  = '0;
   end

   always @(posedge clk) begin
      if (en && we) mem[addr] <= wdata;
      stage1 <= mem[addr];
      rdata  <= stage1;
   end
endmodule

module llq_ctrl_tb_top;
   localparam int NSEG = 64;
   localparam int NQ   = 8;
   localparam int SW   = 6;
   localparam int QW   = 3;
   localparam int AW   = 7;
   localparam int WW   = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_op = 1'b0;
   logic [QW-1:0] req_qid = '0;
   logic [SW-1:0] req_seg = '0;

   logic          a_ready, a_done, a_empty, a_en, a_we;
   logic [SW-1:0] a_seg;
   logic [AW-1:0] a_addr;
   logic [WW-1:0] a_wdata, a_rdata;
   logic          b_ready, b_done, b_empty, b_en, b_we;
   logic [SW-1:0] b_seg;
   logic [AW-1:0] b_addr;
   logic [WW-1:0] b_wdata, b_rdata;

   int n_chk = 0;
   int n_fail = 0;
   int next_seg = 1;
   logic [SW-1:0] ref_buf [NQ][64];
   int ref_wr [NQ];
   int ref_rd [NQ];

   always #2.5 clk = ~clk;

   llq_ctrl #(.NSEG(NSEG), .NQ(NQ), .USE_NULL_PTR(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(a_ready),
      .req_op(req_op), .req_qid(req_qid), .req_seg(req_seg),
      .done_valid(a_done), .done_empty(a_empty), .done_seg(a_seg),
      .mem_en(a_en), .mem_we(a_we), .mem_addr(a_addr), .mem_wdata(a_wdata),
      .mem_rdata(a_rdata)
   );
   llq_tb_sram #(.AW(AW), .WW(WW)) mem_a_i (
      .clk(clk), .en(a_en), .we(a_we), .addr(a_addr), .wdata(a_wdata), .rdata(a_rdata)
   );

   llq_ctrl #(.NSEG(NSEG), .NQ(NQ), .USE_NULL_PTR(1'b1)) dut_null_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(b_ready),
      .req_op(req_op), .req_qid(req_qid), .req_seg(req_seg),
      .done_valid(b_done), .done_empty(b_empty), .done_seg(b_seg),
      .mem_en(b_en), .mem_we(b_we), .mem_addr(b_addr), .mem_wdata(b_wdata),
      .mem_rdata(b_rdata)
   );
   llq_tb_sram #(.AW(AW), .WW(WW)) mem_b_i (
      .clk(clk), .en(b_en), .we(b_we), .addr(b_addr), .wdata(b_wdata), .rdata(b_rdata)
   );

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_op(input logic op, input int q, input bit poke);
      int lat = 1;
      int cnt_a = 0;
      int cnt_b = 0;
      int last_rd = -100;
      bit seen = 1'b0;
      bit exp_empty = 1'b0;
      int exp_seg = 0;
      int exp_cnt;
      int exp_edges;
      int seg = next_seg;
      string req;
      if (op == 1'b0) begin
         req = (ref_wr[q] == ref_rd[q]) ? "R4" : "R5";
         exp_cnt = 3; exp_edges = 5; exp_seg = seg;
         ref_buf[q][ref_wr[q] % 64] = SW'(seg);
         ref_wr[q]++;
         next_seg = (next_seg + 1) % NSEG;
      end else if (ref_wr[q] == ref_rd[q]) begin
         req = "R6"; exp_cnt = 1; exp_edges = 3; exp_empty = 1'b1; exp_seg = 0;
      end else begin
         exp_seg = int'(ref_buf[q][ref_rd[q] % 64]);
         if (ref_wr[q] - ref_rd[q] == 1) begin
            req = "R7"; exp_edges = 8;
         end else begin
            req = "R8"; exp_edges = 10;
         end
         exp_cnt = 4;
         ref_rd[q]++;
      end
      while (!a_ready) @(negedge clk);
      req_valid = 1'b1; req_op = op; req_qid = QW'(q); req_seg = SW'(seg);
      @(negedge clk);
      req_valid = 1'b0;
      while (!seen && lat < 40) begin
         if (poke) begin
            if (lat <= 3) begin
               check_eq("R3", "ready while busy", int'(a_ready), 0);
               req_valid = 1'b1; req_op = 1'b0; req_qid = QW'(7); req_seg = SW'(63);
            end else begin
               req_valid = 1'b0;
            end
         end
         if (a_en) begin
            cnt_a++;
            if (lat - last_rd < 3) begin
               n_chk++; n_fail++;
               $display("FAIL R9 access gap after read: actual %0d expected >=3", lat - last_rd);
            end
            if (!a_we) last_rd = lat;
         end
         if (b_en) cnt_b++;
         if (a_done) begin
            seen = 1'b1;
         end else begin
            @(negedge clk);
            lat++;
         end
      end
      req_valid = 1'b0;
      check_eq(req, "completion edge", lat - 1, exp_edges);
      check_eq(req, "access count", cnt_a, exp_cnt);
      check_eq("R11", "access count reserved-value", cnt_b, exp_cnt);
      check_eq("R11", "done reserved-value", int'(b_done), 1);
      if (seen) begin
         check_eq("R10", "ready at done", int'(a_ready), 1);
         check_eq(req, "empty status", int'(a_empty), int'(exp_empty));
         check_eq("R11", "empty reserved-value", int'(b_empty), int'(exp_empty));
         if (op == 1'b1 && !exp_empty) begin
            check_eq(req, "dequeued segment", int'(a_seg), exp_seg);
            check_eq("R11", "dequeued segment reserved-value", int'(b_seg), exp_seg);
         end
         @(negedge clk);
         check_eq("R10", "done pulse width", int'(a_done), 0);
      end
   endtask

   task automatic t_reset();
      int writes = 0;
      for (int q = 0; q < NQ; q++) begin ref_wr[q] = 0; ref_rd[q] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_eq("R1", "ready right after reset", int'(a_ready), 0);
      for (int i = 0; i < 100 && !a_ready; i++) begin
         if (a_en && a_we) writes++;
         @(negedge clk);
      end
      check_eq("R1", "init writes", writes, 2 * NQ);
      check_eq("R1", "ready after init", int'(a_ready), 1);
      for (int q = 0; q < NQ; q++) begin
         check_eq("R2", "empty head word", int'(mem_a_i.mem[NSEG + q]), NSEG);
         check_eq("R2", "empty tail word reserved-value", int'(mem_b_i.mem[NSEG + NQ + q]), NSEG);
      end
      for (int q = 0; q < NQ; q++) do_op(1'b1, q, 1'b0);
   endtask

   task automatic t_single();
      int s0 = next_seg;
      do_op(1'b0, 0, 1'b0);
      check_eq("R2", "head word after first enqueue", int'(mem_a_i.mem[NSEG]), s0);
      check_eq("R2", "tail word after first enqueue", int'(mem_a_i.mem[NSEG + NQ]), s0);
      do_op(1'b0, 0, 1'b0);
      check_eq("R2", "next-pointer of old tail", int'(mem_a_i.mem[s0]), s0 + 1);
      check_eq("R2", "next-pointer reserved-value", int'(mem_b_i.mem[s0]), s0 + 1);
      do_op(1'b1, 0, 1'b0);
      do_op(1'b1, 0, 1'b0);
      check_eq("R7", "head word after drain", int'(mem_a_i.mem[NSEG]), NSEG);
      check_eq("R7", "tail word after drain", int'(mem_a_i.mem[NSEG + NQ]), NSEG);
      do_op(1'b1, 0, 1'b0);
   endtask

   task automatic t_alternate();
      for (int i = 0; i < 24; i++) begin
         do_op(1'b0, i % 5, 1'b0);
         do_op(1'b1, (i + 2) % 5, 1'b0);
      end
   endtask

   task automatic t_busy_poke();
      do_op(1'b0, 2, 1'b1);
      do_op(1'b1, 7, 1'b0);
   endtask

   task automatic t_fill_drain();
      for (int i = 0; i < 10; i++) do_op(1'b0, 6, 1'b0);
      for (int i = 0; i < 11; i++) do_op(1'b1, 6, 1'b0);
      do_op(1'b0, 6, 1'b0);
      do_op(1'b1, 6, 1'b0);
   endtask

   initial begin
      t_reset();
      t_single();
      t_alternate();
      t_busy_poke();
      t_fill_drain();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule